// File: doc/BRIEF.md
# Performance-mode clock rate selector

This block takes a single fast base clock, nominally 208 MHz, and produces one-cycle clock-enable strobes for four downstream clock domains: the CPU, the interconnect peripherals, the external-memory interface and the fast peripheral bridge. Each domain's strobe repeats every N base cycles, where N is 208 MHz divided by the domain's target rate. A three-bit performance-mode field in a control register picks the targets. Each domain has its own rate ladder, and the ladders are not proportional to one another. The two slowest modes put every domain on a rate derived from 13 MHz.

Writing a different mode starts a modelled PLL re-lock. The lock flag in the status register drops for a fixed number of cycles, and the old rates stay in force. When the flag rises, the new mode becomes the applied mode. Each domain's divider then takes its new period only when its current period ends, so no strobe interval is ever cut short. Software reaches the control field and the lock flag through a small register port: a one-bit address, a write strobe and a combinational read-data bus. Control and status are plain pins; no data stream flows through the block.

Top module: `perf_rate_strobe`

## Requirements
- R1: The mode field is control bits [2:0]. The codes are 0 best, 1 high, 2 intermediate, 3 low and 4 low-power. Codes 5 to 7 behave as low-power. Reset selects code 0 with the lock flag set.
- R2: The CPU strobe period is 16, 16, 4, 2 and 1 base cycles in low-power, low, intermediate, high and best (13/13/52/104/208 MHz). A period of 1 keeps the strobe high.
- R3: The interconnect strobe period is 32, 32, 8, 4 and 4 cycles in those modes (6.5/6.5/26/52/52 MHz).
- R4: The external-memory strobe period is 16, 16, 4, 2 and 2 cycles (13/13/52/104/104 MHz).
- R5: The fast-bridge strobe period is 16 cycles in low-power and low, and 8 cycles (26 MHz) in every other mode.
- R6: A write with reg_addr=0 replaces only bits [2:0] of the control register. Bits [15:3] always read as CTRL_FIXED[15:3]. A write with reg_addr=1 changes nothing.
- R7: A read with reg_addr=1 returns the lock flag in bit 0 and zeros in bits [15:1].
- R8: A control write whose mode differs from the stored mode clears the lock flag for exactly LOCK_CYCLES cycles, starting in the cycle after the write. Another differing write during that time restarts the count. A write of the stored mode leaves the flag alone.
- R9: While the lock flag is clear, the strobes keep the previously applied rates. After the flag sets, each domain takes its new period only at its next strobe, so every gap between strobes is a whole old period or a whole new period.
- R10: Every strobe with a period above 1 is high for exactly one base cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock (208 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for the selected register (combinational) |
| cpu_stb | output | 1 | CPU domain clock-enable strobe |
| icn_stb | output | 1 | Interconnect peripheral clock-enable strobe |
| mem_stb | output | 1 | External-memory interface clock-enable strobe |
| fbr_stb | output | 1 | Fast-bridge clock-enable strobe |

## Verification
The bench builds the block with LOCK_CYCLES set to 6 and CTRL_FIXED left at 16'h5A00. The short re-lock window lets many mode changes finish within one run. It also makes three cases common rather than rare: a write that lands inside a re-lock, a re-lock that ends partway through a 32-cycle interconnect period, and back-to-back changes that restart the count. The non-zero fixed pattern shows any write that disturbs the bits outside the mode field.

// File: rtl/perf_rate_pkg.sv
package perf_rate_pkg;
  localparam int CTRL_W = 16;
  localparam int MODE_W = 3;
  localparam int NDOM   = 4;
  localparam int DIV_W  = 6;

  typedef enum logic [MODE_W-1:0] {
    PM_BEST = 3'd0,
    PM_HIGH = 3'd1,
    PM_MID  = 3'd2,
    PM_LOW  = 3'd3,
    PM_LP   = 3'd4
  } perf_mode_e;

  // domain index: 0 cpu, 1 interconnect, 2 external memory, 3 fast bridge
  function automatic logic [DIV_W-1:0] period_of(input int dom, input logic [MODE_W-1:0] mode);
    int lvl;
    logic [DIV_W-1:0] p;
    case (mode)
      3'd0:    lvl = 3;
      3'd1:    lvl = 2;
      3'd2:    lvl = 1;
      default: lvl = 0;
    endcase
    p = DIV_W'(16);
    case (dom)
      0: case (lvl) 0: p = DIV_W'(16); 1: p = DIV_W'(4); 2: p = DIV_W'(2); default: p = DIV_W'(1); endcase
      1: case (lvl) 0: p = DIV_W'(32); 1: p = DIV_W'(8); default: p = DIV_W'(4); endcase
      2: case (lvl) 0: p = DIV_W'(16); 1: p = DIV_W'(4); default: p = DIV_W'(2); endcase
      default: p = (lvl == 0) ? DIV_W'(16) : DIV_W'(8);
    endcase
    return p;
  endfunction
endpackage

// File: rtl/perf_mode_ctl.sv
module perf_mode_ctl
  import perf_rate_pkg::*;
#(
  parameter int LOCK_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_vld,
  input  logic [MODE_W-1:0] wr_mode,
  output logic [MODE_W-1:0] mode_q,
  output logic [MODE_W-1:0] applied_q,
  output logic              locked
);
  localparam int LCW = $clog2(LOCK_CYCLES + 1);

  logic [LCW-1:0] lock_cnt;
  logic           change;

  assign change = wr_vld && (wr_mode != mode_q);
  assign locked = (lock_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_W'(PM_BEST);
      applied_q <= MODE_W'(PM_BEST);
      lock_cnt  <= '0;
    end else if (change) begin
      mode_q   <= wr_mode;
      lock_cnt <= LCW'(LOCK_CYCLES);
    end else if (lock_cnt != '0) begin
      lock_cnt <= lock_cnt - 1'b1;
      if (lock_cnt == LCW'(1)) applied_q <= mode_q;
    end
  end
endmodule

// File: rtl/perf_strobe_div.sv
module perf_strobe_div
  import perf_rate_pkg::*;
#(
  parameter int DOM = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  output logic              stb_o
);
  logic [DIV_W-1:0] per_q;
  logic [DIV_W-1:0] cnt_q;

  assign stb_o = (cnt_q == per_q - 1'b1);

  // period reloads only at a strobe, so an interval is never cut short
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= period_of(DOM, MODE_W'(PM_BEST));
    end else if (stb_o) begin
      cnt_q <= '0;
      per_q <= period_of(DOM, mode_i);
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/perf_rate_strobe.sv
module perf_rate_strobe
  import perf_rate_pkg::*;
#(
  parameter int               LOCK_CYCLES = 64,
  parameter logic [CTRL_W-1:0] CTRL_FIXED = 16'h5A00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  output logic              cpu_stb,
  output logic              icn_stb,
  output logic              mem_stb,
  output logic              fbr_stb
);
  logic [MODE_W-1:0] mode_q;
  logic [MODE_W-1:0] applied_q;
  logic              locked;
  logic [NDOM-1:0]   stb;

  perf_mode_ctl #(.LOCK_CYCLES(LOCK_CYCLES)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_vld    (reg_we && !reg_addr),
    .wr_mode   (reg_wdata[MODE_W-1:0]),
    .mode_q    (mode_q),
    .applied_q (applied_q),
    .locked    (locked)
  );

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    perf_strobe_div #(.DOM(d)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_i (applied_q),
      .stb_o  (stb[d])
    );
  end

  assign cpu_stb = stb[0];
  assign icn_stb = stb[1];
  assign mem_stb = stb[2];
  assign fbr_stb = stb[3];

  assign reg_rdata = reg_addr ? {{(CTRL_W-1){1'b0}}, locked}
                              : {CTRL_FIXED[CTRL_W-1:MODE_W], mode_q};
endmodule

// File: rtl/perf_rate_strobe_chk.sv
module perf_rate_strobe_chk
  import perf_rate_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic              reg_addr,
  input logic [CTRL_W-1:0] reg_wdata,
  input logic [MODE_W-1:0] mode_q,
  input logic [MODE_W-1:0] applied_q,
  input logic              locked,
  input logic              icn_stb,
  input logic              mem_stb,
  input logic              fbr_stb
);
  // R8
  relock_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_addr && reg_wdata[MODE_W-1:0] != mode_q) |=> !locked);

  // R6
  status_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr) |=> $stable(mode_q));

  // R9
  lock_applied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (applied_q == mode_q));

  // R9
  hold_old_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> $stable(applied_q));

  // R10
  icn_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    icn_stb |=> !icn_stb);

  // R10
  mem_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_stb |=> !mem_stb);

  // R10
  fbr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fbr_stb |=> !fbr_stb);
endmodule

bind perf_rate_strobe perf_rate_strobe_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .mode_q    (mode_q),
  .applied_q (applied_q),
  .locked    (locked),
  .icn_stb   (icn_stb),
  .mem_stb   (mem_stb),
  .fbr_stb   (fbr_stb)
);

// File: tb/perf_rate_strobe_bench.sv
module perf_rate_strobe_bench;
  localparam int          LOCK  = 6;
  localparam logic [15:0] FIXED = 16'h5A00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        cpu_stb, icn_stb, mem_stb, fbr_stb;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  perf_rate_strobe #(.LOCK_CYCLES(LOCK), .CTRL_FIXED(FIXED)) u_perf_rate_strobe (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_stb(cpu_stb), .icn_stb(icn_stb), .mem_stb(mem_stb), .fbr_stb(fbr_stb)
  );

  // periods per ladder step: slow(lp/low/reserved), intermediate, high, best
  function automatic int ref_period(input int d, input logic [2:0] m);
    int step;
    int cpu_p[4] = '{16, 4, 2, 1};
    int icn_p[4] = '{32, 8, 4, 4};
    int mem_p[4] = '{16, 4, 2, 2};
    int fbr_p[4] = '{16, 8, 8, 8};
    step = (m == 3'd0) ? 3 : (m == 3'd1) ? 2 : (m == 3'd2) ? 1 : 0;
    case (d)
      0: return cpu_p[step];
      1: return icn_p[step];
      2: return mem_p[step];
      default: return fbr_p[step];
    endcase
  endfunction

  function automatic logic get_stb(input int d);
    case (d)
      0: return cpu_stb;
      1: return icn_stb;
      2: return mem_stb;
      default: return fbr_stb;
    endcase
  endfunction

  function automatic string dom_req(input int d);
    case (d)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model of the requirements
  logic [2:0] m_mode, m_act;
  int m_lock;
  int m_cnt[4];
  int m_per[4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= 3'd0;
      m_act  <= 3'd0;
      m_lock <= 0;
      for (int d = 0; d < 4; d++) begin
        m_cnt[d] <= 0;
        m_per[d] <= ref_period(d, 3'd0);
      end
    end else begin
      if (reg_we && !reg_addr && reg_wdata[2:0] != m_mode) begin
        m_mode <= reg_wdata[2:0];
        m_lock <= LOCK;
      end else if (m_lock > 0) begin
        m_lock <= m_lock - 1;
        if (m_lock == 1) m_act <= m_mode;
      end
      for (int d = 0; d < 4; d++) begin
        if (m_cnt[d] == m_per[d] - 1) begin
          m_cnt[d] <= 0;
          m_per[d] <= ref_period(d, m_act);
        end else begin
          m_cnt[d] <= m_cnt[d] + 1;
        end
      end
    end
  end

  // R9: cycle-by-cycle comparison of strobes and registers
  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      for (int d = 0; d < 4; d++)
        check(dom_req(d), "R9 strobe vs model", int'(get_stb(d)), int'(m_cnt[d] == m_per[d] - 1));
      if (reg_addr)
        check("R8", "lock flag vs model", int'(reg_rdata), int'(m_lock == 0));
      else
        check("R6", "control readback vs model", int'(reg_rdata), int'((FIXED & 16'hFFF8) | {13'd0, m_mode}));
    end
  end

  task automatic wr(input logic a, input logic [15:0] v);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input logic a, input string req, input int exp);
    reg_addr = a;
    @(negedge clk);
    check(req, a ? "status read" : "control read", int'(reg_rdata), exp);
  endtask

  task automatic gap_check(input int d, input int exp);
    int g;
    @(negedge clk);
    while (!get_stb(d)) @(negedge clk);
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!get_stb(d) && g < 100);
    check(dom_req(d), "strobe period", g, exp);
  endtask

  task automatic set_mode_settle(input logic [2:0] m);
    wr(1'b0, FIXED | {13'd0, m});
    repeat (LOCK + 70) @(posedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed = 32'd1357;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    rd_check(1'b0, "R1", int'(FIXED));
    rd_check(1'b1, "R7", 1);
    check("R2", "cpu strobe high in best mode", int'(cpu_stb), 1);
    cmp_on = 1'b1;

    // R8: exact re-lock window after a change to low-power
    wr(1'b0, 16'h0004);
    reg_addr = 1'b1;
    @(negedge clk);
    check("R8", "lock low after change", int'(reg_rdata), 0);
    repeat (LOCK - 1) @(posedge clk);
    @(negedge clk);
    check("R8", "lock still low at last cycle", int'(reg_rdata), 0);
    @(posedge clk);
    @(negedge clk);
    check("R8", "lock back after window", int'(reg_rdata), 1);
    rd_check(1'b0, "R6", int'(FIXED | 16'h0004));
    repeat (70) @(posedge clk);
    gap_check(0, 16); gap_check(1, 32); gap_check(2, 16); gap_check(3, 16);

    // R1: reserved code behaves as low-power
    set_mode_settle(3'd6);
    gap_check(0, 16); gap_check(1, 32);
    rd_check(1'b0, "R1", int'(FIXED | 16'h0006));

    // R8: rewriting the stored mode leaves lock alone
    wr(1'b0, 16'h0006);
    rd_check(1'b1, "R8", 1);

    // R6: other bits ignored, status write ignored
    wr(1'b0, 16'hFFFA);
    repeat (LOCK + 2) @(posedge clk);
    rd_check(1'b0, "R6", int'(FIXED | 16'h0002));
    wr(1'b1, 16'hFFFF);
    rd_check(1'b0, "R6", int'(FIXED | 16'h0002));
    rd_check(1'b1, "R7", 1);
    repeat (70) @(posedge clk);
    gap_check(0, 4); gap_check(1, 8); gap_check(2, 4); gap_check(3, 8);

    set_mode_settle(3'd1);
    gap_check(0, 2); gap_check(1, 4); gap_check(2, 2); gap_check(3, 8);
    set_mode_settle(3'd3);
    gap_check(0, 16); gap_check(1, 32); gap_check(2, 16); gap_check(3, 16);
    set_mode_settle(3'd0);
    gap_check(0, 1); gap_check(1, 4); gap_check(2, 2); gap_check(3, 8);

    // R8: restart of the count by a second change
    wr(1'b0, 16'h0004);
    repeat (3) @(posedge clk);
    wr(1'b0, 16'h0002);
    reg_addr = 1'b1;
    repeat (LOCK - 1) @(posedge clk);
    @(negedge clk);
    check("R8", "restarted lock still low", int'(reg_rdata), 0);
    @(posedge clk);
    @(negedge clk);
    check("R8", "restarted lock back", int'(reg_rdata), 1);

    // R9: random traffic against the model
    for (int i = 0; i < 500; i++) begin
      case ($urandom % 4)
        0: wr(1'b0, 16'($urandom));
        1: wr(1'b1, 16'($urandom));
        2: begin
          reg_addr = 1'($urandom);
          repeat ($urandom % 40) @(posedge clk);
        end
        default: begin
          reg_addr = 1'($urandom);
          repeat (LOCK + 40) @(posedge clk);
        end
      endcase
    end
    @(negedge clk);
    finish_run();
  end
endmodule